// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked front end of a common-I/O burst SRAM with a small internal word array. On every rising clock edge it samples three chip enables, two address strobes, an advance input, the write controls, the address and a burst-order select. From these it decides whether to start a read, start a write, continue a burst, or deselect.

The block keeps a 2-bit wrapping burst count beside a registered start address. The low two address bits of each beat follow either linear order (start plus count, modulo 4) or interleaved order (start XOR count). Read data reaches the output in flow-through fashion: the word at the registered burst address appears in the same cycle. The output-drive enable for the shared data bus is removed whenever the current write controls request a write to any byte lane.

A host uses the processor strobe to start reads and the controller strobe to start reads or writes. It then pulses the advance input to walk through up to four beats, and it can write single byte lanes during those beats.

Top module: `sburst_sram`

## Requirements
- R1: After reset the device is deselected, and `dout_en` stays low even with `oe_n` low until an access is started.
- R2: With all enables active (`en_a_n`=0, `en_b`=1, `en_c_n`=0), `ctrl_strb_n`=0, `proc_strb_n`=1 and a write requested, `din` is written at the edge to the word at `addr`.
- R3: When `proc_strb_n` is low, `ctrl_strb_n` is ignored. The access is a read start that loads `addr`, and the write controls have no effect on the array at that edge.
- R4: `gw_n`=0 writes all four byte lanes. Otherwise `bwe_n`=0 together with `bw_n[i]`=0 writes only lane i (bits 8i+7:8i). Any other combination is a read.
- R5: While selected, `dout` equals the word at the registered burst address in the same cycle, and `dout_en` is high when no write is requested and `oe_n` is low.
- R6: Whenever any lane write is requested, including a single-byte write, `dout_en` is low whatever `oe_n` is.
- R7: With `burst_mode`=0 the low address bits step start, start+1, start+2, start+3, modulo 4.
- R8: With `burst_mode`=1 the low address bits step start XOR 0, 1, 2, 3 (start 10 gives 10,11,00,01; start 11 gives 11,10,01,00).
- R9: In a selected cycle with no strobe, `adv_n`=0 steps the burst count by one and `adv_n`=1 holds it. After four steps the address is back at the start.
- R10: A strobe seen while any enable is inactive deselects the device. It writes nothing, and `dout_en` then stays low.
- R11: In a selected cycle with no strobe, a requested write stores the enabled lanes of `din` at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| proc_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-lane write strobes, active low |
| addr | input | AW | Word address |
| burst_mode | input | 1 | 0 linear order, 1 interleaved order |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8*NB | Write data from the bus |
| dout | output | 8*NB | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bench builds the block with the default AW=4 and NB=4: a 16-word array of four byte lanes. With that size every location a scenario touches can be filled with distinct values, so a wrong burst step, a stray lane write or a write through the ignored strobe shows up as a mismatching word. One burst window of four words is read back in both orders from several start offsets, including the wrap past the window end. The four lanes let each single-lane write be checked against its three untouched neighbours.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_DESEL,
    ACC_START_RD,
    ACC_START_WR,
    ACC_CONT
  } acc_kind_t;

  // Low two bits of a burst beat: linear adds the count, interleaved XORs it.
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/sbs_access_decode.sv
module sbs_access_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          proc_strb_n,
  input  logic          ctrl_strb_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic          sel_q,
  output acc_kind_t     kind,
  output logic [NB-1:0] lane_req,
  output logic          wr_any
);

  logic enabled;
  assign enabled = ~en_a_n & en_b & ~en_c_n;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_req[i] = ~gw_n | (~bwe_n & ~bw_n[i]);
  end

  assign wr_any = |lane_req;

  // Processor strobe outranks controller strobe.
  always_comb begin
    kind = ACC_NONE;
    if (!proc_strb_n) begin
      kind = enabled ? ACC_START_RD : ACC_DESEL;
    end else if (!ctrl_strb_n) begin
      if (enabled) kind = wr_any ? ACC_START_WR : ACC_START_RD;
      else         kind = ACC_DESEL;
    end else if (sel_q) begin
      kind = ACC_CONT;
    end
  end

  // R3: a processor strobe never yields a write start
  assert_proc_strobe_wins_R3 : assert property (@(posedge clk) disable iff (!rst_q)
    !proc_strb_n |-> kind != ACC_START_WR);

  // R10: a strobe without full selection always deselects
  assert_strobe_desel_R10 : assert property (@(posedge clk) disable iff (!rst_q)
    ((!proc_strb_n || !ctrl_strb_n) && (en_a_n || !en_b || en_c_n)) |-> kind == ACC_DESEL);

  // R4: global write asks for every lane
  assert_global_all_lanes_R4 : assert property (@(posedge clk) disable iff (!rst_q)
    !gw_n |-> &lane_req);

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          load,
  input  logic          advance,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] burst_addr
);

  localparam int HW = AW - 2;

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = 2'd0;
    end else if (advance) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign burst_addr = {base_q[AW-1:2], burst_lsb(base_q[1:0], cnt_q, interleave)};

  // R9: a load seeds the counter from the presented address
  assert_load_seeds_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    load |=> (cnt_q == 2'd0) && (base_q == $past(addr_in)));

  // R9: advancing steps the count by one, wrapping at four
  assert_advance_steps_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    (advance && !load) |=> cnt_q == $past(cnt_q) + 2'd1);

  // R9: without load or advance the beat holds
  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    (!advance && !load) |=> $stable(cnt_q) && $stable(base_q));

  // R7: in linear order each advance adds one to the low bits
  assert_linear_step_R7 : assert property (@(posedge clk) disable iff (!rst_q)
    (advance && !load && !interleave) |=>
      (interleave || burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1));

  // R9: the upper address bits never move during a burst
  assert_upper_fixed_R9 : assert property (@(posedge clk) disable iff (!rst_q)
    !load |=> burst_addr[AW-1:2] == $past(burst_addr[AW-1:2]));

  logic [HW-1:0] unused_hw;
  assign unused_hw = base_q[AW-1:2];

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic [NB-1:0]   we,
  input  logic [AW-1:0]   waddr,
  input  logic [8*NB-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [8*NB-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) lane_mem[waddr] <= wdata[8*i +: 8];
    end

    assign rdata[8*i +: 8] = lane_mem[raddr];
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_a_n,
  input  logic            en_b,
  input  logic            en_c_n,
  input  logic            proc_strb_n,
  input  logic            ctrl_strb_n,
  input  logic            adv_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [NB-1:0]   bw_n,
  input  logic [AW-1:0]   addr,
  input  logic            burst_mode,
  input  logic            oe_n,
  input  logic [8*NB-1:0] din,
  output logic [8*NB-1:0] dout,
  output logic            dout_en
);

  logic [1:0]    rst_pipe;
  logic          rst_q;
  acc_kind_t     kind;
  logic [NB-1:0] lane_req;
  logic          wr_any;
  logic          sel_q, sel_d;
  logic          load, advance;
  logic [AW-1:0] burst_addr, waddr;
  logic [NB-1:0] mem_we;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  sbs_access_decode #(.NB(NB)) u_dec (
    .clk         (clk),
    .rst_q       (rst_q),
    .en_a_n      (en_a_n),
    .en_b        (en_b),
    .en_c_n      (en_c_n),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .gw_n        (gw_n),
    .bwe_n       (bwe_n),
    .bw_n        (bw_n),
    .sel_q       (sel_q),
    .kind        (kind),
    .lane_req    (lane_req),
    .wr_any      (wr_any)
  );

  always_comb begin
    sel_d = sel_q;
    case (kind)
      ACC_START_RD, ACC_START_WR: sel_d = 1'b1;
      ACC_DESEL:                  sel_d = 1'b0;
      default:                    sel_d = sel_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign load    = (kind == ACC_START_RD) || (kind == ACC_START_WR);
  assign advance = (kind == ACC_CONT) && !adv_n;

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk        (clk),
    .rst_q      (rst_q),
    .load       (load),
    .advance    (advance),
    .interleave (burst_mode),
    .addr_in    (addr),
    .burst_addr (burst_addr)
  );

  always_comb begin
    mem_we = '0;
    waddr  = burst_addr;
    if (kind == ACC_START_WR) begin
      mem_we = lane_req;
      waddr  = addr;
    end else if (kind == ACC_CONT) begin
      mem_we = lane_req;
    end
  end

  sbs_mem_array #(.AW(AW), .NB(NB)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (din),
    .raddr (burst_addr),
    .rdata (dout)
  );

  assign dout_en = sel_q & ~wr_any & ~oe_n;

  // R6: any requested lane write keeps the bus undriven
  assert_no_drive_on_write_R6 : assert property (@(posedge clk) disable iff (!rst_q)
    (!gw_n || (!bwe_n && (bw_n != {NB{1'b1}}))) |-> !dout_en);

  // R10: after a deselecting strobe the bus is not driven
  assert_desel_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_q)
    (kind == ACC_DESEL) |=> !dout_en);

  // R3: a processor strobe leaves the array untouched at that edge
  assert_proc_no_write_R3 : assert property (@(posedge clk) disable iff (!rst_q)
    !proc_strb_n |-> mem_we == '0);

  // R5: a read start with output enabled drives the bus on the next cycle
  assert_read_drives_R5 : assert property (@(posedge clk) disable iff (!rst_q)
    (kind == ACC_START_RD) |=> (oe_n || wr_any || dout_en));

endmodule

// File: tb/sim_sburst_sram.sv
`timescale 1ns/100ps
module sim_sburst_sram;

  logic        clk;
  logic        rst_n;
  logic        en_a_n, en_b, en_c_n;
  logic        proc_strb_n, ctrl_strb_n, adv_n;
  logic        gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic [3:0]  addr;
  logic        burst_mode, oe_n;
  logic [31:0] din, dout;
  logic        dout_en;

  int checks;
  int errors;
  bit done;
  logic [31:0] ref_mem [16];

  sburst_sram #(.AW(4), .NB(4)) u0 (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr),
    .burst_mode(burst_mode), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF; oe_n = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic g, input logic be, input logic [3:0] b);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!g || (!be && !b[i])) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  task automatic ctrl_write(input logic [3:0] a, input logic [31:0] d,
                            input logic g, input logic be, input logic [3:0] b);
    idle();
    ctrl_strb_n = 1'b0; addr = a; din = d; gw_n = g; bwe_n = be; bw_n = b;
    step();
    ref_mem[a] = merge(ref_mem[a], d, g, be, b);
    idle();
  endtask

  task automatic proc_start(input logic [3:0] a);
    idle();
    proc_strb_n = 1'b0; addr = a;
    step();
    idle();
    #1;
  endtask

  task automatic t_reset();
    idle();
    #1;
    check("R1 dout_en after reset", {31'd0, dout_en}, 32'd0);
    step();
    #1;
    check("R1 dout_en idle cycle", {31'd0, dout_en}, 32'd0);
  endtask

  task automatic t_word_write();
    ctrl_write(4'd3, 32'hA5A5_0103, 1'b0, 1'b1, 4'hF);
    ctrl_write(4'd4, 32'h1234_5678, 1'b0, 1'b1, 4'hF);
    proc_start(4'd3);
    check("R2 word at 3", dout, ref_mem[3]);
    check("R5 dout_en on read", {31'd0, dout_en}, 32'd1);
    proc_start(4'd4);
    check("R2 word at 4", dout, 32'h1234_5678);
  endtask

  task automatic t_byte_write();
    ctrl_write(4'd6, 32'hDDCC_BBAA, 1'b0, 1'b1, 4'hF);
    ctrl_write(4'd6, 32'h1122_3344, 1'b1, 1'b0, 4'b1101);
    proc_start(4'd6);
    check("R4 lane1 only", dout, 32'hDDCC_33AA);
    // byte strobes without byte-write enable: plain read start, no write
    ctrl_write(4'd6, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);
    proc_start(4'd6);
    check("R4 bw_n without bwe_n ignored", dout, 32'hDDCC_33AA);
  endtask

  task automatic t_priority();
    ctrl_write(4'd5, 32'hCAFE_0005, 1'b0, 1'b1, 4'hF);
    proc_start(4'd2);
    idle();
    proc_strb_n = 1'b0; ctrl_strb_n = 1'b0; gw_n = 1'b0; addr = 4'd5; din = 32'hBAD0_BAD0;
    step();
    idle();
    #1;
    check("R3 proc strobe wins, no write", dout, 32'hCAFE_0005);
    check("R3 address loaded, bus driven", {31'd0, dout_en}, 32'd1);
  endtask

  task automatic t_tristate_cont();
    // selected at word 5, beat 0
    idle();
    bwe_n = 1'b0; bw_n = 4'b1110; din = 32'h0000_00EE;
    #1;
    check("R6 byte write blocks drive", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b1;
    #0.5;
    check("R6 byte write with oe_n high", {31'd0, dout_en}, 32'd0);
    step();
    ref_mem[5] = merge(ref_mem[5], 32'h0000_00EE, 1'b1, 1'b0, 4'b1110);
    idle();
    #1;
    check("R11 continuation lane write", dout, 32'hCAFE_00EE);
    gw_n = 1'b0;
    #0.5;
    check("R6 global write blocks drive", {31'd0, dout_en}, 32'd0);
    idle();
    oe_n = 1'b1;
    #0.5;
    check("R5 oe_n high no drive", {31'd0, dout_en}, 32'd0);
    step();
    idle();
    #1;
    check("R11 no write without write controls", dout, 32'hCAFE_00EE);
  endtask

  task automatic t_burst(input logic mode, input logic [1:0] start, input string req);
    logic [1:0] lsb;
    burst_mode = mode;
    proc_start({2'b10, start});
    for (int k = 0; k < 4; k++) begin
      lsb = mode ? (start ^ 2'(k)) : (start + 2'(k));
      check(req, dout, ref_mem[{2'b10, lsb}]);
      adv_n = 1'b0;
      step();
      adv_n = 1'b1;
      #1;
    end
    check("R9 wrap to start", dout, ref_mem[{2'b10, start}]);
    step();
    #1;
    check("R9 hold with adv_n high", dout, ref_mem[{2'b10, start}]);
  endtask

  task automatic t_bursts();
    for (int i = 0; i < 4; i++)
      ctrl_write(4'(8 + i), 32'hB000_0000 + 32'(i * 17 + 1), 1'b0, 1'b1, 4'hF);
    t_burst(1'b0, 2'd1, "R7 linear beat");
    t_burst(1'b0, 2'd3, "R7 linear beat");
    t_burst(1'b1, 2'd2, "R8 interleaved beat");
    t_burst(1'b1, 2'd3, "R8 interleaved beat");
    burst_mode = 1'b0;
  endtask

  task automatic t_deselect();
    proc_start(4'd3);
    idle();
    en_b = 1'b0; ctrl_strb_n = 1'b0; gw_n = 1'b0; addr = 4'd3; din = 32'hDEAD_DEAD;
    step();
    idle();
    #1;
    check("R10 deselected no drive", {31'd0, dout_en}, 32'd0);
    step();
    #1;
    check("R10 stays deselected", {31'd0, dout_en}, 32'd0);
    proc_start(4'd3);
    check("R10 no write while deselecting", dout, ref_mem[3]);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    for (int i = 0; i < 16; i++) ref_mem[i] = 32'd0;
    idle();
    burst_mode = 1'b0; addr = 4'd0; din = 32'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_write();
    t_byte_write();
    t_priority();
    t_tristate_cont();
    t_bursts();
    t_deselect();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule